// File: doc/BRIEF.md
# Load-Use Stall and Taken-Branch Flush Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) running a RISC-V style integer instruction set. It is purely combinational. Each cycle it looks at the instruction sitting in decode and the instruction sitting in execute. From them it derives four steering signals: the program-counter write enable, the fetch/decode register write enable, a bubble request for the decode/execute register, and a flush request for the fetch/decode register. The pipeline datapath uses these signals to hold, squash or advance its stage registers. The operand forwarding multiplexers live elsewhere.

**Load-use stall.** A value loaded from memory reaches the end of the memory stage one cycle too late to be forwarded into an ALU operand in the following cycle. So when decode reads a register that a load in execute is about to write, the front of the pipeline is held for exactly one cycle and a no-op (`addi x0, x0, 0`, word `32'h00000013`) is steered into execute. Two cases are exempt:

- Register zero never creates a dependency.
- A store whose only link to the load is its data operand can proceed, because the loaded value can be forwarded from writeback into the memory stage in time.

**Taken-branch flush.** Fetch always assumes a branch falls through. The branch outcome is known at the end of execute. When it is taken, the two younger instructions already in fetch and decode are turned into no-ops and fetch is redirected. This flush overrides a simultaneous load-use stall.

Top module: `hzd_ctrl`

## Requirements
- R1: With no load-use dependency and no taken branch, the outputs are `pc_we`=1, `ifid_we`=1, `idex_bubble`=0, `ifid_flush`=0.
- R2: When `ex_is_load`=1, `ex_rd` is nonzero, `id_use_rs1`=1 and `id_rs1` equals `ex_rd`, the block stalls: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1, `ifid_flush`=0.
- R3: When `ex_is_load`=1, `ex_rd` is nonzero, `id_use_rs2`=1, `id_rs2` equals `ex_rd` and `id_class` is not the store code (3), the block stalls as in R2.
- R4: With `STORE_DATA_BYPASS`=1, a decode instruction of class store (`id_class`=3) whose only match with a nonzero load destination is `id_rs2` does not stall. A match on its `id_rs1` still stalls. With `STORE_DATA_BYPASS`=0, the `id_rs2` match stalls as well.
- R5: A load whose destination index is 0 never causes a stall, whatever the source indices are.
- R6: A source whose use flag is 0 never causes a stall, even when its index equals the load destination.
- R7: When `ex_is_load`=0, no stall occurs, whatever the register indices are.
- R8: When `ex_br_taken`=1, the outputs are `pc_we`=1, `ifid_we`=1, `idex_bubble`=1 and `ifid_flush`=1. This squashes both younger slots and lets the target be fetched.
- R9: When `ex_br_taken`=1 coincides with a load-use dependency, the R8 outputs apply and no stall is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_IDX_W | First source register index of the decode instruction |
| id_rs2 | input | REG_IDX_W | Second source register index of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_class | input | 3 | Decode opcode class (0 reg ALU, 1 imm ALU, 2 load, 3 store, 4 branch, 5 jump, 6 upper-imm, 7 system) |
| ex_is_load | input | 1 | Execute instruction reads data memory |
| ex_rd | input | REG_IDX_W | Destination register index of the execute instruction |
| ex_br_taken | input | 1 | Branch in execute resolved as taken |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Replace the fetch/decode content with a no-op |

## Verification
The bench builds two copies of the block, both with `REG_IDX_W`=5 and the register-zero exemption on.

- The main copy keeps `STORE_DATA_BYPASS`=1. This makes the store-data exemption observable against a base-register match on the same load.
- The second copy uses `STORE_DATA_BYPASS`=0. It shows that the same store-data match then stalls.

The five-bit index width lets the vectors reach the extreme index 31 as well as register zero. The vectors cover coinciding branch and load hazards, which demonstrates the flush priority.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   // Opcode classes presented by the decode stage
   typedef enum logic [2:0] {
      CLS_ALU_REG = 3'd0,
      CLS_ALU_IMM = 3'd1,
      CLS_LOAD    = 3'd2,
      CLS_STORE   = 3'd3,
      CLS_BRANCH  = 3'd4,
      CLS_JUMP    = 3'd5,
      CLS_UPPER   = 3'd6,
      CLS_SYSTEM  = 3'd7
   } insn_class_e;

   localparam int unsigned CLASS_W = 3;

   // Encoding of the no-op steered into squashed slots
   localparam logic [31:0] NOP_WORD = 32'h0000_0013;

   // Steering bundle toward the pipeline registers
   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic idex_bubble;
      logic ifid_flush;
   } hzd_ctl_t;

endpackage

// File: rtl/hzd_src_match.sv
// Compares one decode source against the execute-stage destination.
module hzd_src_match #(
   parameter int unsigned IDX_W       = 5,
   parameter bit          ZERO_EXEMPT = 1'b1
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic             src_used,
   input  logic [IDX_W-1:0] dst_idx,
   input  logic             dst_valid,
   output logic             hit
);

   logic same_idx;
   logic dst_live;

   assign same_idx = (src_idx == dst_idx);

   generate
      if (ZERO_EXEMPT) begin : g_zero_exempt
         assign dst_live = dst_valid && (dst_idx != '0);
      end else begin : g_zero_live
         assign dst_live = dst_valid;
      end
   endgenerate

   assign hit = src_used && dst_live && same_idx;

endmodule

// File: rtl/hzd_loaduse.sv
// Detects a decode instruction that needs the result of a load in execute.
module hzd_loaduse
   import hzd_pkg::*;
#(
   parameter int unsigned IDX_W             = 5,
   parameter bit          ZERO_EXEMPT       = 1'b1,
   parameter bit          STORE_DATA_BYPASS = 1'b1
) (
   input  logic [IDX_W-1:0]   rs1,
   input  logic [IDX_W-1:0]   rs2,
   input  logic               use_rs1,
   input  logic               use_rs2,
   input  logic [CLASS_W-1:0] op_class,
   input  logic               ex_load,
   input  logic [IDX_W-1:0]   ex_dst,
   output logic               stall_req
);

   localparam int unsigned NUM_SRC = 2;

   logic [IDX_W-1:0] src_idx  [NUM_SRC];
   logic             src_used [NUM_SRC];
   logic [NUM_SRC-1:0] src_hit;
   logic             data_only_ok;

   assign src_idx[0]  = rs1;
   assign src_idx[1]  = rs2;
   assign src_used[0] = use_rs1;
   assign src_used[1] = use_rs2;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      hzd_src_match #(
         .IDX_W       (IDX_W),
         .ZERO_EXEMPT (ZERO_EXEMPT)
      ) u_match (
         .src_idx   (src_idx[s]),
         .src_used  (src_used[s]),
         .dst_idx   (ex_dst),
         .dst_valid (ex_load),
         .hit       (src_hit[s])
      );
   end

   // Second-source match is forgiven for stores when the loaded value can
   // reach the memory stage through writeback forwarding.
   generate
      if (STORE_DATA_BYPASS) begin : g_store_bypass
         assign data_only_ok = (insn_class_e'(op_class) == CLS_STORE);
      end else begin : g_store_strict
         logic unused_class;
         assign unused_class = ^op_class;
         assign data_only_ok = 1'b0;
      end
   endgenerate

   assign stall_req = src_hit[0] || (src_hit[1] && !data_only_ok);

endmodule

// File: rtl/hzd_steer.sv
// Turns stall and redirect requests into pipeline-register controls.
module hzd_steer
   import hzd_pkg::*;
(
   input  logic     stall_req,
   input  logic     redirect,
   output hzd_ctl_t ctl
);

   always_comb begin
      ctl = '{pc_we: 1'b1, ifid_we: 1'b1, idex_bubble: 1'b0, ifid_flush: 1'b0};
      if (redirect) begin
         // both wrong-path slots become no-ops; fetch moves to the target
         ctl.idex_bubble = 1'b1;
         ctl.ifid_flush  = 1'b1;
      end else if (stall_req) begin
         ctl.pc_we       = 1'b0;
         ctl.ifid_we     = 1'b0;
         ctl.idex_bubble = 1'b1;
      end
   end

endmodule

// File: rtl/hzd_ctrl.sv
// Load-use stall and taken-branch flush controller (top).
module hzd_ctrl
   import hzd_pkg::*;
#(
   parameter int unsigned REG_IDX_W         = 5,
   parameter bit          ZERO_EXEMPT       = 1'b1,
   parameter bit          STORE_DATA_BYPASS = 1'b1
) (
   input  logic [REG_IDX_W-1:0] id_rs1,
   input  logic [REG_IDX_W-1:0] id_rs2,
   input  logic                 id_use_rs1,
   input  logic                 id_use_rs2,
   input  logic [2:0]           id_class,
   input  logic                 ex_is_load,
   input  logic [REG_IDX_W-1:0] ex_rd,
   input  logic                 ex_br_taken,
   output logic                 pc_we,
   output logic                 ifid_we,
   output logic                 idex_bubble,
   output logic                 ifid_flush
);

   generate
      if (REG_IDX_W < 1 || REG_IDX_W > 8) begin : g_bad_idx_w
         $error("hzd_ctrl: REG_IDX_W must lie in 1..8");
      end
      if (CLASS_W != 3) begin : g_bad_class_w
         $error("hzd_ctrl: opcode class width must be 3");
      end
   endgenerate

   logic     stall_req;
   hzd_ctl_t ctl;

   hzd_loaduse #(
      .IDX_W             (REG_IDX_W),
      .ZERO_EXEMPT       (ZERO_EXEMPT),
      .STORE_DATA_BYPASS (STORE_DATA_BYPASS)
   ) u_loaduse (
      .rs1       (id_rs1),
      .rs2       (id_rs2),
      .use_rs1   (id_use_rs1),
      .use_rs2   (id_use_rs2),
      .op_class  (id_class),
      .ex_load   (ex_is_load),
      .ex_dst    (ex_rd),
      .stall_req (stall_req)
   );

   hzd_steer u_steer (
      .stall_req (stall_req),
      .redirect  (ex_br_taken),
      .ctl       (ctl)
   );

   assign pc_we       = ctl.pc_we;
   assign ifid_we     = ctl.ifid_we;
   assign idex_bubble = ctl.idex_bubble;
   assign ifid_flush  = ctl.ifid_flush;

   // Checks relating the detector, the steering and the ports
   always_comb begin
      if (!$isunknown({id_rs1, id_rs2, id_use_rs1, id_use_rs2, id_class,
                       ex_is_load, ex_rd, ex_br_taken})) begin
         AST_FREE_FLOW: assert (stall_req || ex_br_taken ||
                                (pc_we && ifid_we && !idex_bubble && !ifid_flush)); // R1
         AST_STALL_HOLDS_FRONT: assert (!(stall_req && !ex_br_taken) ||
                                (!pc_we && !ifid_we && idex_bubble && !ifid_flush)); // R2
         AST_BASE_MATCH_STALLS: assert (!(ex_is_load && ex_rd != '0 && id_use_rs1 &&
                                id_rs1 == ex_rd) || stall_req); // R2
         AST_STORE_DATA_FREE: assert (!(STORE_DATA_BYPASS && id_class == 3'd3 &&
                                !(id_use_rs1 && id_rs1 == ex_rd)) || !stall_req); // R4
         AST_ZERO_DEST_QUIET: assert (!(ZERO_EXEMPT && ex_rd == '0) || !stall_req); // R5
         AST_NON_LOAD_QUIET: assert (ex_is_load || !stall_req); // R7
         AST_FLUSH_WINS: assert (!ex_br_taken ||
                                (pc_we && ifid_we && idex_bubble && ifid_flush)); // R9
      end
   end

endmodule

// File: tb/hzd_ctrl_bench.sv
`timescale 1ns/1ps
module hzd_ctrl_bench;

   localparam int unsigned IW = 5;

   // expected output pattern {pc_we, ifid_we, idex_bubble, ifid_flush}
   localparam logic [3:0] RUN   = 4'b1100;
   localparam logic [3:0] STALL = 4'b0010;
   localparam logic [3:0] FLUSH = 4'b1111;

   typedef struct packed {
      logic [IW-1:0] rs1;
      logic [IW-1:0] rs2;
      logic          u1;
      logic          u2;
      logic [2:0]    cls;
      logic          ld;
      logic [IW-1:0] rd;
      logic          tk;
      logic [3:0]    exp;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{5'd1,  5'd2,  1'b1, 1'b1, 3'd0, 1'b0, 5'd3,  1'b0, RUN,   4'd1}, // R1 no load
      '{5'd1,  5'd2,  1'b1, 1'b1, 3'd0, 1'b1, 5'd3,  1'b0, RUN,   4'd1}, // R1 load, no match
      '{5'd5,  5'd0,  1'b1, 1'b0, 3'd1, 1'b1, 5'd5,  1'b0, STALL, 4'd2}, // R2 imm on rs1
      '{5'd7,  5'd9,  1'b1, 1'b1, 3'd0, 1'b1, 5'd7,  1'b0, STALL, 4'd2}, // R2 reg on rs1
      '{5'd4,  5'd9,  1'b1, 1'b1, 3'd0, 1'b1, 5'd9,  1'b0, STALL, 4'd3}, // R3 reg on rs2
      '{5'd4,  5'd12, 1'b1, 1'b1, 3'd4, 1'b1, 5'd12, 1'b0, STALL, 4'd3}, // R3 branch on rs2
      '{5'd1,  5'd12, 1'b1, 1'b1, 3'd3, 1'b1, 5'd12, 1'b0, RUN,   4'd4}, // R4 store data only
      '{5'd12, 5'd6,  1'b1, 1'b1, 3'd3, 1'b1, 5'd12, 1'b0, STALL, 4'd4}, // R4 store base
      '{5'd0,  5'd0,  1'b1, 1'b1, 3'd0, 1'b1, 5'd0,  1'b0, RUN,   4'd5}, // R5 x0
      '{5'd4,  5'd5,  1'b0, 1'b1, 3'd0, 1'b1, 5'd4,  1'b0, RUN,   4'd6}, // R6 rs1 unused
      '{5'd3,  5'd4,  1'b1, 1'b0, 3'd1, 1'b1, 5'd4,  1'b0, RUN,   4'd6}, // R6 rs2 unused
      '{5'd4,  5'd4,  1'b1, 1'b1, 3'd0, 1'b0, 5'd4,  1'b0, RUN,   4'd7}, // R7 not a load
      '{5'd1,  5'd2,  1'b1, 1'b1, 3'd0, 1'b0, 5'd3,  1'b1, FLUSH, 4'd8}, // R8 taken branch
      '{5'd8,  5'd8,  1'b1, 1'b1, 3'd0, 1'b1, 5'd8,  1'b1, FLUSH, 4'd9}, // R9 flush beats stall
      '{5'd31, 5'd31, 1'b1, 1'b1, 3'd0, 1'b1, 5'd31, 1'b0, STALL, 4'd3}  // R3 top index
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [IW-1:0] id_rs1, id_rs2, ex_rd;
   logic id_use_rs1, id_use_rs2, ex_is_load, ex_br_taken;
   logic [2:0] id_class;
   logic pc_we, ifid_we, idex_bubble, ifid_flush;
   logic s_pc_we, s_ifid_we, s_idex_bubble, s_ifid_flush;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   hzd_ctrl u_hzd_ctrl (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
      .id_class(id_class), .ex_is_load(ex_is_load), .ex_rd(ex_rd), .ex_br_taken(ex_br_taken),
      .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
   );

   hzd_ctrl #(.STORE_DATA_BYPASS(1'b0)) u_hzd_ctrl_strict (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
      .id_class(id_class), .ex_is_load(ex_is_load), .ex_rd(ex_rd), .ex_br_taken(ex_br_taken),
      .pc_we(s_pc_we), .ifid_we(s_ifid_we), .idex_bubble(s_idex_bubble), .ifid_flush(s_ifid_flush)
   );

   task automatic drive(input vec_t v);
      @(posedge clk);
      id_rs1 = v.rs1; id_rs2 = v.rs2; id_use_rs1 = v.u1; id_use_rs2 = v.u2;
      id_class = v.cls; ex_is_load = v.ld; ex_rd = v.rd; ex_br_taken = v.tk;
      @(negedge clk);
   endtask

   task automatic check(input logic [3:0] got, input logic [3:0] exp,
                        input int req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   initial begin
      id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 1'b0; id_use_rs2 = 1'b0;
      id_class = 3'd0; ex_is_load = 1'b0; ex_rd = '0; ex_br_taken = 1'b0;

      // quiet inputs: free flow (R1)
      @(negedge clk);
      check({pc_we, ifid_we, idex_bubble, ifid_flush}, RUN, 1, "quiet inputs");

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         check({pc_we, ifid_we, idex_bubble, ifid_flush}, VECS[i].exp,
               int'(VECS[i].req), $sformatf("vector %0d", i));
      end

      // R4 strict variant: store-data match stalls without the bypass
      drive('{5'd1, 5'd12, 1'b1, 1'b1, 3'd3, 1'b1, 5'd12, 1'b0, STALL, 4'd4});
      check({s_pc_we, s_ifid_we, s_idex_bubble, s_ifid_flush}, STALL, 4, "strict store data");
      check({pc_we, ifid_we, idex_bubble, ifid_flush}, RUN, 4, "bypass store data");

      // R2 stall lasts one cycle: the load leaves execute, flow resumes
      drive('{5'd6, 5'd0, 1'b1, 1'b0, 3'd1, 1'b1, 5'd6, 1'b0, STALL, 4'd2});
      check({pc_we, ifid_we, idex_bubble, ifid_flush}, STALL, 2, "stall cycle");
      drive('{5'd6, 5'd0, 1'b1, 1'b0, 3'd1, 1'b0, 5'd0, 1'b0, RUN, 4'd2});
      check({pc_we, ifid_we, idex_bubble, ifid_flush}, RUN, 2, "release after stall");

      // R5 x0 with a store base match on register zero
      drive('{5'd0, 5'd0, 1'b1, 1'b1, 3'd3, 1'b1, 5'd0, 1'b0, RUN, 4'd5});
      check({s_pc_we, s_ifid_we, s_idex_bubble, s_ifid_flush}, RUN, 5, "x0 strict store");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule